// File: doc/BRIEF.md
# Two-Area Ping-Pong Audio Address Sequencer

This block produces the byte address stream for an audio channel whose samples live in two separate memory areas that are used in turn. Software sets a base address and a byte length for each area, picks a sample format, and sets a run bit. Each time the downstream transfer logic asks for a step, the block advances the offset inside the active area by the sample size in bytes. At the end of an area it switches to the other one on that same step, with no idle cycle in between. It also reports the absolute address, the offset inside the active area, and which area is active.

Each area has its own completion flag. Software clears a flag by writing a one to its bit. A read returns the live status, not the value that was last written. The two flags are ORed into one level interrupt. Clearing the run bit freezes the walk at its current position, and setting it again resumes from that position. An area of zero length counts as empty. The sequencer passes over it, sets its flag, and restarts the other area.

Top module: `pingpong_dma_seq`

## Requirements
- R1: After reset the control word, both base addresses, both lengths, the offset, the position and the completion flags read zero, the format register reads 0x10, the active area is area 1 and irq is low.
- R2: In the format register (address 7) only bit 4 (16-bit samples) and bit 5 (stereo) are writable, and other bits read zero. The step size is 1 byte for 8-bit mono, 2 bytes for 16-bit mono or 8-bit stereo, and 4 bytes for 16-bit stereo.
- R3: A step request advances the walk only while control bit 0 (address 0) is set. While it is clear, step requests leave the offset, position and area unchanged. Setting it again resumes from the held position.
- R4: The position output and register 5 equal the active area's base address (area 1 at address 2, area 2 at address 3) plus the offset. Each accepted step that does not end the area adds the step size to the offset (output and register 6).
- R5: When offset plus step reaches or passes the active area's length (address 4: area 1 in bits 15:0, area 2 in bits 31:16), that step sets the area's completion flag (area 1 → bit 1, area 2 → bit 2 of address 1). On the same step, the walk moves to offset 0 of the other area.
- R6: Writing address 1 clears each flag whose bit is written as one and leaves the others alone. Writing all ones clears both flags. A read of address 1 returns the flag status.
- R7: If a step sets a flag in the same cycle that software writes a one to clear that flag, the flag ends up set.
- R8: When the area the walk would move to has length zero, the step sets that area's flag as well, and the walk restarts at offset 0 of the area it just finished.
- R9: irq is high whenever either completion flag is set, and it stays high until a register write clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 32 | Register read data (combinational) |
| stepReq | input | 1 | Request to advance by one sample |
| curAddr | output | 32 | Absolute byte address of the current sample |
| curOffset | output | 16 | Byte offset inside the active area |
| activeArea | output | 1 | 0 when area 1 is active, 1 when area 2 is active |
| irq | output | 1 | Level interrupt, OR of the two completion flags |

## Verification
A step that ends an area can land in the same cycle as a software write that clears that area's flag. That collision decides whether a completion event is lost. The bench sets up a walk that is one step short of the end of area 1, then raises the step request and the flag-clear write on the same clock edge. It expects the flag to read as set afterwards and irq to stay high. A separate, non-colliding clear shows that the write path itself does clear the flag.

// File: rtl/pingpong_dma_seq_pkg.sv
package pingpong_dma_seq_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_FLAGS  = 3'd1;
  localparam logic [REG_AW-1:0] RA_BASE1  = 3'd2;
  localparam logic [REG_AW-1:0] RA_BASE2  = 3'd3;
  localparam logic [REG_AW-1:0] RA_LENS   = 3'd4;
  localparam logic [REG_AW-1:0] RA_POS    = 3'd5;
  localparam logic [REG_AW-1:0] RA_OFFSET = 3'd6;
  localparam logic [REG_AW-1:0] RA_FORMAT = 3'd7;

  localparam int FMT_WIDE_BIT   = 4;
  localparam int FMT_STEREO_BIT = 5;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic       advance;   // accepted step
    logic       wrap;      // step ends the active area
    logic       stayPut;   // wrap, but the other area is empty
    logic [2:0] stepBytes; // bytes per sample
  } seqStrobe_t;

endpackage

// File: rtl/pingpong_dma_seq_ctrl.sv
module pingpong_dma_seq_ctrl
  import pingpong_dma_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              stepReq,
  input  logic              endHit,
  input  logic              otherEmpty,
  input  logic              activeArea,
  output seqStrobe_t        strobes,
  output logic              runBit,
  output logic [1:0]        fmtBits,
  output logic [1:0]        doneFlags
);

  logic [1:0] setMask;
  logic [1:0] ackMask;
  logic [1:0] shiftAmt;

  assign shiftAmt = {1'b0, fmtBits[0]} + {1'b0, fmtBits[1]};

  always_comb begin
    strobes.advance   = stepReq && runBit;
    strobes.wrap      = strobes.advance && endHit;
    strobes.stayPut   = strobes.wrap && otherEmpty;
    strobes.stepBytes = 3'd1 << shiftAmt;
  end

  always_comb begin
    setMask = 2'b00;
    if (strobes.wrap) begin
      setMask[activeArea] = 1'b1;
      if (strobes.stayPut) setMask[~activeArea] = 1'b1;
    end
    ackMask = (regWr && regAddr == RA_FLAGS) ? regWrData[2:1] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      fmtBits   <= 2'b01;
      doneFlags <= 2'b00;
    end else begin
      if (regWr && regAddr == RA_CTRL) runBit <= regWrData[0];
      if (regWr && regAddr == RA_FORMAT)
        fmtBits <= {regWrData[FMT_STEREO_BIT], regWrData[FMT_WIDE_BIT]};
      doneFlags <= (doneFlags & ~ackMask) | setMask;
    end
  end

endmodule

// File: rtl/pingpong_dma_seq_dp.sv
module pingpong_dma_seq_dp
  import pingpong_dma_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  seqStrobe_t        strobes,
  output logic              endHit,
  output logic              otherEmpty,
  output logic              activeArea,
  output logic [PTR_W-1:0]  baseOut [2],
  output logic [LEN_W-1:0]  lenOut [2],
  output logic [PTR_W-1:0]  curAddr,
  output logic [LEN_W-1:0]  curOffset
);

  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] nextOff;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_area
      logic [REG_AW-1:0] baseSel;
      assign baseSel = (g == 0) ? RA_BASE1 : RA_BASE2;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseOut[g] <= '0;
          lenOut[g]  <= '0;
        end else if (regWr) begin
          if (regAddr == baseSel) baseOut[g] <= regWrData[PTR_W-1:0];
          if (regAddr == RA_LENS) lenOut[g] <= regWrData[g*LEN_W +: LEN_W];
        end
      end
    end
  endgenerate

  assign nextOff    = SUM_W'(curOffset) + SUM_W'(strobes.stepBytes);
  assign endHit     = nextOff >= SUM_W'(lenOut[activeArea]);
  assign otherEmpty = lenOut[~activeArea] == '0;
  assign curAddr    = baseOut[activeArea] + PTR_W'(curOffset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOffset  <= '0;
      activeArea <= 1'b0;
    end else if (strobes.wrap) begin
      curOffset <= '0;
      if (!strobes.stayPut) activeArea <= ~activeArea;
    end else if (strobes.advance) begin
      curOffset <= nextOff[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/pingpong_dma_seq.sv
module pingpong_dma_seq
  import pingpong_dma_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic [2:0]        regRdAddr,
  output logic [31:0]       regRdData,
  input  logic              stepReq,
  output logic [31:0]       curAddr,
  output logic [15:0]       curOffset,
  output logic              activeArea,
  output logic              irq
);

  seqStrobe_t       strobes;
  logic             endHit;
  logic             otherEmpty;
  logic             runBit;
  logic [1:0]       fmtBits;
  logic [1:0]       doneFlags;
  logic [PTR_W-1:0] baseOut [2];
  logic [LEN_W-1:0] lenOut [2];

  pingpong_dma_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .stepReq(stepReq), .endHit(endHit),
    .otherEmpty(otherEmpty), .activeArea(activeArea), .strobes(strobes),
    .runBit(runBit), .fmtBits(fmtBits), .doneFlags(doneFlags)
  );

  pingpong_dma_seq_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes), .endHit(endHit),
    .otherEmpty(otherEmpty), .activeArea(activeArea), .baseOut(baseOut),
    .lenOut(lenOut), .curAddr(curAddr), .curOffset(curOffset)
  );

  assign irq = |doneFlags;

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      RA_CTRL:   regRdData[0] = runBit;
      RA_FLAGS:  regRdData[2:1] = doneFlags;
      RA_BASE1:  regRdData = 32'(baseOut[0]);
      RA_BASE2:  regRdData = 32'(baseOut[1]);
      RA_LENS:   regRdData = {16'(lenOut[1]), 16'(lenOut[0])};
      RA_POS:    regRdData = 32'(curAddr);
      RA_OFFSET: regRdData = 32'(curOffset);
      RA_FORMAT: begin
        regRdData[FMT_WIDE_BIT]   = fmtBits[0];
        regRdData[FMT_STEREO_BIT] = fmtBits[1];
      end
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/pingpong_dma_seq_chk.sv
module pingpong_dma_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stepReq,
  input logic        runBit,
  input logic        regWr,
  input logic [15:0] curOffset,
  input logic        activeArea,
  input logic        irq,
  input logic [2:0]  stepBytes
);

  // R3
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> $stable(curOffset));

  // R4
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && runBit) |=>
      (curOffset == 16'd0) || (curOffset == $past(curOffset) + 16'($past(stepBytes))));

  // R5
  area_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeArea) |-> curOffset == 16'd0);

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(stepReq && runBit));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWr) |=> irq);

endmodule

bind pingpong_dma_seq pingpong_dma_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .stepReq(stepReq), .runBit(runBit), .regWr(regWr),
  .curOffset(curOffset), .activeArea(activeArea), .irq(irq),
  .stepBytes(strobes.stepBytes)
);

// File: tb/sim_pingpong_dma_seq.sv
`timescale 1ns/1ps
module sim_pingpong_dma_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        stepReq = 1'b0;
  logic [31:0] curAddr;
  logic [15:0] curOffset;
  logic        activeArea;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  pingpong_dma_seq u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .stepReq(stepReq), .curAddr(curAddr), .curOffset(curOffset),
    .activeArea(activeArea), .irq(irq)
  );

  // reference model, built from the requirements
  logic [31:0] mBase [2];
  logic [15:0] mLen [2];
  logic [31:0] mFmt;
  logic        mRun;
  int          mArea;
  int          mOff;
  logic [1:0]  mFlags;

  typedef struct {
    logic [31:0] addr;
    logic [15:0] off;
    logic        area;
    logic        irqLvl;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mBase[0] = '0; mBase[1] = '0; mLen[0] = '0; mLen[1] = '0;
    mFmt = 32'h10; mRun = 1'b0; mArea = 0; mOff = 0; mFlags = 2'b00;
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: mRun = d[0];
      3'd1: mFlags = mFlags & ~d[2:1];
      3'd2: mBase[0] = d;
      3'd3: mBase[1] = d;
      3'd4: begin mLen[0] = d[15:0]; mLen[1] = d[31:16]; end
      3'd7: mFmt = d & 32'h30;
      default: ;
    endcase
  endtask

  task automatic modelStep(input logic [1:0] ack);
    logic [1:0] setM;
    int stp;
    int nOff;
    setM = 2'b00;
    if (mRun) begin
      stp = 1 << (int'(mFmt[4]) + int'(mFmt[5]));
      nOff = mOff + stp;
      if (nOff >= int'(mLen[mArea])) begin
        setM[mArea] = 1'b1;
        mOff = 0;
        if (mLen[1-mArea] == 16'd0) setM[1-mArea] = 1'b1;
        else mArea = 1 - mArea;
      end else begin
        mOff = nOff;
      end
    end
    mFlags = (mFlags & ~ack) | setM;
  endtask

  task automatic pushExp(input string tag);
    expItem_t e;
    e.addr = mBase[mArea] + 32'(mOff);
    e.off = 16'(mOff);
    e.area = (mArea == 1);
    e.irqLvl = |mFlags;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    modelWrite(a, d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regCheck(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    regRdAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  // driver: one step, optionally colliding with a flag-clear write
  task automatic doStep(input string tag, input logic ackWr, input logic [31:0] ackData);
    @(negedge clk);
    stepReq = 1'b1;
    if (ackWr) begin
      regWr = 1'b1; regAddr = 3'd1; regWrData = ackData;
      modelStep(ackData[2:1]);
    end else begin
      modelStep(2'b00);
    end
    pushExp(tag);
    @(negedge clk);
    stepReq = 1'b0;
    regWr = 1'b0;
  endtask

  // monitor: compares each result after the step's clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " addr"}, curAddr, e.addr);
        check({e.tag, " offset"}, 32'(curOffset), 32'(e.off));
        check({e.tag, " area"}, 32'(activeArea), 32'(e.area));
        check({e.tag, " irq"}, 32'(irq), 32'(e.irqLvl));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    modelReset();
    doReset();

    // R1 reset state
    regCheck("R1 ctrl", 3'd0, 32'h0);
    regCheck("R1 flags", 3'd1, 32'h0);
    regCheck("R1 base1", 3'd2, 32'h0);
    regCheck("R1 base2", 3'd3, 32'h0);
    regCheck("R1 lens", 3'd4, 32'h0);
    regCheck("R1 pos", 3'd5, 32'h0);
    regCheck("R1 offset", 3'd6, 32'h0);
    regCheck("R1 format", 3'd7, 32'h10);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 only format bits 4 and 5 stick
    regWrite(3'd7, 32'hFFFF_FFFF);
    regCheck("R2 format mask", 3'd7, 32'h30);
    regWrite(3'd7, 32'h10);

    regWrite(3'd2, 32'h0000_1000);
    regWrite(3'd3, 32'h0000_2000);
    regWrite(3'd4, 32'h0004_0008);
    regCheck("R4 base1 readback", 3'd2, 32'h1000);
    regCheck("R5 lens readback", 3'd4, 32'h0004_0008);

    // R3 step ignored while stopped
    doStep("R3 stopped", 1'b0, 0);
    regCheck("R3 offset held", 3'd6, 32'h0);

    regWrite(3'd0, 32'h1);
    // R4 / R5 walk: area 1 then area 2 then back
    for (int i = 0; i < 6; i++) doStep("R5 walk", 1'b0, 0);
    regCheck("R5 flags both", 3'd1, 32'h6);
    check("R9 irq set", 32'(irq), 32'h1);
    regCheck("R4 pos reg", 3'd5, 32'h1000);

    // R6 acknowledge
    regWrite(3'd1, 32'h2);
    regCheck("R6 ack area1", 3'd1, 32'h4);
    check("R9 irq still", 32'(irq), 32'h1);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regCheck("R6 ack all", 3'd1, 32'h0);
    check("R9 irq clear", 32'(irq), 32'h0);

    // R3 pause and resume
    doStep("R3 pre-pause", 1'b0, 0);
    regWrite(3'd0, 32'h0);
    doStep("R3 paused", 1'b0, 0);
    doStep("R3 paused", 1'b0, 0);
    regWrite(3'd0, 32'h1);
    doStep("R3 resumed", 1'b0, 0);
    regCheck("R3 offset after resume", 3'd6, 32'h4);

    // R7 completion and acknowledge in the same cycle
    doStep("R7 setup", 1'b0, 0);
    doStep("R7 collide", 1'b1, 32'h2);
    regCheck("R7 flag kept", 3'd1, 32'h2);
    check("R7 irq kept", 32'(irq), 32'h1);

    // R8 empty area, R2 4-byte step
    doReset();
    regWrite(3'd2, 32'h0000_0100);
    regWrite(3'd3, 32'h0000_0300);
    regWrite(3'd4, 32'h0006_0000);
    regWrite(3'd7, 32'h30);
    regWrite(3'd0, 32'h1);
    doStep("R8 skip empty", 1'b0, 0);
    regCheck("R8 flag area1", 3'd1, 32'h2);
    doStep("R2 step4", 1'b0, 0);
    doStep("R8 restart same", 1'b0, 0);
    regCheck("R8 both flags", 3'd1, 32'h6);

    // R2 1-byte step
    regWrite(3'd7, 32'h0);
    doStep("R2 step1", 1'b0, 0);
    regCheck("R2 offset one", 3'd6, 32'h1);
    regWrite(3'd7, 32'h20);
    doStep("R2 stereo8", 1'b0, 0);
    regCheck("R2 offset three", 3'd6, 32'h3);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule